// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block sends and receives 8-bit words over three wires: a serial data output, a serial data input and a serial clock. Bits travel least significant first. Each word is an optional start bit (low), eight data bits, and an optional stop bit (high). In master mode the block makes the serial clock from the system clock. It emits exactly one clock cycle per frame bit, with each half period lasting `cfg_half` system clocks. In slave mode it follows an external clock, which it first passes through a two-flop synchronizer. Serial data is also synchronized before it is sampled.

The clock generator has three options. It can invert the line polarity. It can delay its output by half a bit period. In continuous mode it runs without stopping, and start and stop bits are then the only frame markers. Software writes a word through a parallel write strobe and watches a transmit-empty flag. It reads received words through a parallel read strobe while a receive-full flag is set. Overrun and framing errors are sticky flags, cleared by a single strobe.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `overrun`=0, `frame_err`=0 and `sd_out`=1. With the clock idle, `sck_out` rests at `~cfg_invert`.
- R2: Words are sent and received LSB first. With `cfg_frame`=1 a frame is a low start bit, eight data bits and a high stop bit. With `cfg_frame`=0 a frame is the eight data bits alone.
- R3: In master mode without continuous clocking, each word produces exactly 10 clock cycles when framed and 8 when not. Each clock half lasts `cfg_half` system clocks. Between frames the clock and data lines rest at their idle levels.
- R4: Transmit data changes only on the leading (falling, before any inversion) edge of the internal clock or at the end of a frame. Received data is sampled on the trailing (rising) internal edge.
- R5: With `cfg_invert`=1 the clock line is the inverse of the internal clock. Data is then sampled on the falling edge of the line, and the idle line level is low.
- R6: With `cfg_delay`=1 the master output clock lags the undelayed clock by `cfg_half` system clocks. The first clock fall therefore comes `cfg_half` cycles after the start bit appears, not in the same cycle.
- R7: With `cfg_cont`=1 in master mode the clock toggles even when no word is pending. The receiver recognizes a frame only by a low start bit.
- R8: In slave mode every bit is clocked by `sck_in` edges after synchronization, and the slave transmitter drives its pending word on those edges.
- R9: A `wr_en` pulse stores `wr_data` and clears `tx_empty`. `tx_empty` sets again when the word is loaded into the shifter at the start of its frame.
- R10: A finished word appears on `rd_data` with `rx_full`=1, and `rd_en` clears `rx_full`. If `rd_en` falls in the same cycle as the completion of a new word, the new word is kept with `rx_full`=1 and no overrun.
- R11: If a word completes while `rx_full`=1 and no read is made in that cycle, `overrun` sets and the new word replaces the old one. `overrun` stays set until `err_clr`.
- R12: With `cfg_frame`=1, a low sampled in the stop-bit position sets `frame_err` until `err_clr`. With `cfg_frame`=0, `frame_err` never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: drive the serial clock; 0: follow `sck_in` |
| cfg_frame | input | 1 | Add start and stop bits |
| cfg_delay | input | 1 | Delay the output clock by half a bit |
| cfg_invert | input | 1 | Invert serial clock polarity |
| cfg_cont | input | 1 | Free-running master clock |
| cfg_half | input | DIVW | Master clock half period in system clocks (at least 3 for loopback) |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | W | Word to send |
| tx_empty | output | 1 | No word waiting to be sent |
| rd_en | input | 1 | Read strobe, clears `rx_full` |
| rd_data | output | W | Last received word |
| rx_full | output | 1 | Unread word in `rd_data` |
| overrun | output | 1 | Sticky: a word completed while the previous one was unread |
| frame_err | output | 1 | Sticky: stop bit sampled low |
| err_clr | input | 1 | Clears `overrun` and `frame_err` |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock output |
| sd_in | input | 1 | Serial data input |
| sd_out | output | 1 | Serial data output |

## Verification
Two events can land in the same system cycle: the completion of a received word and a parallel read of the previous word. In slave mode the bench controls the clock, so it times an `rd_en` pulse to the exact cycle in which the final synchronized rising edge completes a second word. It then expects `rx_full` to stay set, `overrun` to stay clear and `rd_data` to hold the new word. The same pattern without the read must raise `overrun`, which shows the bench can tell the two outcomes apart. Random master-mode loopback frames, mixing framing, inversion, delay and divider settings, check data, clock-cycle counts and idle levels.

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int W    = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_frame,
  input  logic            cfg_delay,
  input  logic            cfg_invert,
  input  logic            cfg_cont,
  input  logic [DIVW-1:0] cfg_half,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  output logic            tx_empty,
  input  logic            rd_en,
  output logic [W-1:0]    rd_data,
  output logic            rx_full,
  output logic            overrun,
  output logic            frame_err,
  input  logic            err_clr,
  input  logic            sck_in,
  output logic            sck_out,
  input  logic            sd_in,
  output logic            sd_out
);
  localparam int FW = W + 2;
  localparam int CW = $clog2(FW + 1);

  logic [1:0]      sck_s, sd_s;
  logic            sck_p, sck_i, bit_in;
  logic [DIVW-1:0] hcnt;
  logic            tick, mclk, dclk, go;
  logic            m_fall, m_rise, m_end, fall_ev, rise_ev;
  logic [W-1:0]    tx_hold;
  logic            pend;
  logic [FW-1:0]   tx_sh, tx_frame;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [W-1:0]    rx_sh, shifted, done_word;
  logic            rx_act, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= 2'b11;
      sd_s  <= 2'b11;
      sck_p <= 1'b1;
    end else begin
      sck_s <= {sck_s[0], sck_in};
      sd_s  <= {sd_s[0], sd_in};
      sck_p <= sck_i;
    end

  assign sck_i  = sck_s[1] ^ cfg_invert;
  assign bit_in = sd_s[1];

  assign tick   = (hcnt >= cfg_half - DIVW'(1));
  assign go     = cfg_cont | pend | (tx_cnt != '0);
  assign m_fall = cfg_master & tick & mclk & go;
  assign m_rise = cfg_master & tick & ~mclk;
  assign m_end  = cfg_master & tick & mclk & ~go;
  assign fall_ev = cfg_master ? m_fall : (~sck_i & sck_p);
  assign rise_ev = cfg_master ? m_rise : (sck_i & ~sck_p);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0;
      mclk <= 1'b1;
      dclk <= 1'b1;
    end else begin
      hcnt <= tick ? '0 : hcnt + DIVW'(1);
      if (!cfg_master) begin
        mclk <= 1'b1;
        dclk <= 1'b1;
      end else begin
        if (m_fall) mclk <= 1'b0;
        else if (m_rise) mclk <= 1'b1;
        if (tick) dclk <= mclk;
      end
    end

  assign sck_out = cfg_master ? ((cfg_delay ? dclk : mclk) ^ cfg_invert) : ~cfg_invert;

  assign tx_frame = cfg_frame ? {1'b1, tx_hold, 1'b0} : {2'b11, tx_hold};
  assign tx_empty = ~pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_hold <= '0;
      pend    <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      sd_out  <= 1'b1;
    end else begin
      if (fall_ev) begin
        if (tx_cnt != '0) begin
          sd_out <= tx_sh[0];
          tx_sh  <= {1'b1, tx_sh[FW-1:1]};
          tx_cnt <= tx_cnt - CW'(1);
        end else if (pend) begin
          sd_out <= tx_frame[0];
          tx_sh  <= {1'b1, tx_frame[FW-1:1]};
          tx_cnt <= cfg_frame ? CW'(FW - 1) : CW'(W - 1);
          pend   <= 1'b0;
        end else begin
          sd_out <= 1'b1;
        end
      end else if (m_end) begin
        sd_out <= 1'b1;
      end
      if (wr_en) begin
        tx_hold <= wr_data;
        pend    <= 1'b1;
      end
    end

  assign shifted   = {bit_in, rx_sh[W-1:1]};
  assign done      = rise_ev & (cfg_frame ? (rx_act && rx_cnt == CW'(W)) : (rx_cnt == CW'(W - 1)));
  assign done_word = cfg_frame ? rx_sh : shifted;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh     <= '0;
      rx_cnt    <= '0;
      rx_act    <= 1'b0;
      rd_data   <= '0;
      rx_full   <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (err_clr) begin
        overrun   <= 1'b0;
        frame_err <= 1'b0;
      end
      if (rd_en) rx_full <= 1'b0;
      if (rise_ev) begin
        if (cfg_frame) begin
          if (!rx_act) begin
            if (!bit_in) begin
              rx_act <= 1'b1;
              rx_cnt <= '0;
            end
          end else if (rx_cnt != CW'(W)) begin
            rx_sh  <= shifted;
            rx_cnt <= rx_cnt + CW'(1);
          end else begin
            rx_act <= 1'b0;
            rx_cnt <= '0;
            if (!bit_in) frame_err <= 1'b1;
          end
        end else begin
          rx_sh  <= shifted;
          rx_cnt <= (rx_cnt == CW'(W - 1)) ? '0 : rx_cnt + CW'(1);
        end
      end
      if (done) begin
        rd_data <= done_word;
        rx_full <= 1'b1;
        if (rx_full && !rd_en) overrun <= 1'b1;
      end
    end

  a_r9_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_empty);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done) |=> !rx_full);
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(err_clr));
  a_r12_ferr_framed_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(cfg_frame));
  a_r4_data_on_leading: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_out != $past(sd_out)) |-> $past(fall_ev || m_end));
endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_frame = 1'b0, cfg_delay = 1'b0, cfg_invert = 1'b0, cfg_cont = 1'b0;
  logic [7:0] cfg_half = 8'd4;
  logic wr_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic tx_empty, rx_full, overrun, frame_err, sck_out, sd_out, sd_in;
  logic [7:0] rd_data;
  logic sck_in = 1'b1, tb_sd = 1'b1, lb = 1'b1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign sd_in = lb ? sd_out : tb_sd;

  sync_serial_xcvr i_sync_serial_xcvr (
    .clk, .rst_n, .cfg_master, .cfg_frame, .cfg_delay, .cfg_invert, .cfg_cont, .cfg_half,
    .wr_en, .wr_data, .tx_empty, .rd_en, .rd_data, .rx_full, .overrun, .frame_err, .err_clr,
    .sck_in, .sck_out, .sd_in, .sd_out);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic read_word();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  function automatic int frame_bits(input bit fr);
    return fr ? 10 : 8;
  endfunction

  task automatic master_xfer(input logic [7:0] d, input bit fr, input bit inv, input bit dly, input int half);
    int falls = 0, t_sd = -1, t_ck = -1, stop_at = -1;
    bit prev, lvl;
    @(negedge clk) begin
      cfg_master = 1'b1; cfg_cont = 1'b0; cfg_frame = fr;
      cfg_invert = inv; cfg_delay = dly; cfg_half = 8'(half); lb = 1'b1;
    end
    repeat (2 * half + 2) @(negedge clk);
    chk(sck_out == ~inv, "R5 idle line level", sck_out, ~inv);
    prev = sck_out ^ inv;
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      wr_en = 1'b0;
      lvl = sck_out ^ inv;
      if (prev && !lvl) falls++;
      if (prev && !lvl && t_ck < 0) t_ck = c;
      if (!sd_out && t_sd < 0) t_sd = c;
      prev = lvl;
      if (rx_full && stop_at < 0) stop_at = c + 3 * half;
      if (c == stop_at) break;
    end
    chk(rx_full && rd_data == d, "R2 loopback word", rd_data, d);
    chk(falls == frame_bits(fr), "R3 clock cycles per word", falls, frame_bits(fr));
    chk(sck_out == ~inv && sd_out == 1'b1, "R3 idle after frame", {sck_out, sd_out}, {~inv, 1'b1});
    if (fr) chk(t_ck - t_sd == (dly ? half : 0), "R6 clock offset to start bit", t_ck - t_sd, dly ? half : 0);
    read_word();
    chk(!rx_full, "R10 read clears full", rx_full, 0);
  endtask

  task automatic slave_bit(input bit b, input int half, input bit rd_here, output bit got);
    @(negedge clk) begin sck_in = cfg_invert; tb_sd = b; end
    repeat (half) @(negedge clk);
    got = sd_out;
    sck_in = ~cfg_invert;
    if (rd_here) begin
      @(negedge clk);
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      repeat (half - 3) @(negedge clk);
    end else begin
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic slave_frame(input logic [9:0] bits, input int n, input bit rd_last, output logic [9:0] out);
    bit g;
    out = '1;
    for (int i = 0; i < n; i++) begin
      slave_bit(bits[i], 6, rd_last && i == n - 1, g);
      out[i] = g;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [9:0] so;
    logic [7:0] a, b;
    int falls;
    bit prev, lvl;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(tx_empty && !rx_full && !overrun && !frame_err, "R1 reset flags",
        {tx_empty, rx_full, overrun, frame_err}, 4'b1000);
    chk(sd_out && sck_out, "R1 reset line levels", {sd_out, sck_out}, 2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    master_xfer(8'hA5, 1'b1, 1'b0, 1'b0, 4);
    master_xfer(8'h01, 1'b0, 1'b0, 1'b0, 3);
    master_xfer(8'h80, 1'b1, 1'b1, 1'b0, 5);
    master_xfer(8'h3C, 1'b1, 1'b0, 1'b1, 4);
    master_xfer(8'hFE, 1'b0, 1'b1, 1'b1, 6);
    for (int i = 0; i < 20; i++)
      master_xfer(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3 + int'($urandom % 4));

    // R9: tx_empty clears on write and returns when the frame begins
    @(negedge clk) begin cfg_frame = 1'b1; cfg_invert = 1'b0; cfg_delay = 1'b0; cfg_half = 8'd4; end
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h5A; end
    @(negedge clk) wr_en = 1'b0;
    chk(!tx_empty, "R9 write clears empty", tx_empty, 0);
    repeat (12) @(negedge clk);
    chk(tx_empty, "R9 empty after load", tx_empty, 1);
    wait (rx_full);
    read_word();

    // R11 overrun with master loopback, no reads between words
    clear_err();
    a = 8'h12; b = 8'hED;
    write_word(a);
    wait (rx_full);
    write_word(b);
    repeat (150) @(negedge clk);
    chk(overrun, "R11 overrun set", overrun, 1);
    chk(rd_data == b, "R11 new word overwrites", rd_data, b);
    repeat (20) @(negedge clk);
    chk(overrun, "R11 overrun sticky", overrun, 1);
    clear_err();
    chk(!overrun, "R11 overrun cleared", overrun, 0);
    read_word();

    // R7 continuous clock
    @(negedge clk) begin cfg_cont = 1'b1; cfg_frame = 1'b1; cfg_half = 8'd4; end
    falls = 0; prev = sck_out;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      lvl = sck_out;
      if (prev && !lvl) falls++;
      prev = lvl;
    end
    chk(falls >= 9 && tx_empty && !rx_full, "R7 free-running clock with no data", falls, 10);
    write_word(8'hC3);
    for (int c = 0; c < 400 && !rx_full; c++) @(negedge clk);
    chk(rx_full && rd_data == 8'hC3, "R7 start-bit framed word in continuous mode", rd_data, 8'hC3);
    read_word();
    repeat (100) @(negedge clk);
    chk(!rx_full, "R7 no false frame while idle", rx_full, 0);
    @(negedge clk) cfg_cont = 1'b0;
    repeat (20) @(negedge clk);

    // R8 slave framed transfer, both directions
    @(negedge clk) begin cfg_master = 1'b0; lb = 1'b0; cfg_frame = 1'b1; cfg_invert = 1'b0; end
    repeat (4) @(negedge clk);
    clear_err();
    write_word(8'h6B);
    slave_frame({1'b1, 8'h94, 1'b0}, 10, 1'b0, so);
    repeat (4) @(negedge clk);
    chk(rx_full && rd_data == 8'h94, "R8 slave receive", rd_data, 8'h94);
    chk(so == {1'b1, 8'h6B, 1'b0}, "R8 slave transmit bits", so, {1'b1, 8'h6B, 1'b0});
    chk(!frame_err, "R12 good stop bit", frame_err, 0);
    read_word();

    // R12 framing error
    slave_frame({1'b0, 8'h47, 1'b0}, 10, 1'b0, so);
    repeat (4) @(negedge clk);
    chk(frame_err, "R12 low stop bit flagged", frame_err, 1);
    read_word();
    clear_err();

    // R5 slave inverted, unframed; R12 no framing error without framing
    @(negedge clk) begin cfg_frame = 1'b0; cfg_invert = 1'b1; sck_in = 1'b1; end
    repeat (4) @(negedge clk);
    chk(sck_out == 1'b0, "R5 inverted idle line", sck_out, 0);
    slave_frame({2'b00, 8'h00}, 8, 1'b0, so);
    repeat (4) @(negedge clk);
    chk(rx_full && rd_data == 8'h00 && !frame_err, "R12 unframed all-zero word", {frame_err, rd_data}, 0);
    slave_frame({2'b00, 8'hB2}, 8, 1'b0, so);
    repeat (4) @(negedge clk);
    chk(rd_data == 8'hB2 && overrun, "R5 inverted sampling, R11 slave overrun", {overrun, rd_data}, {1'b1, 8'hB2});
    clear_err();

    // R10 read in the completion cycle of a new word
    slave_frame({2'b00, 8'h9D}, 8, 1'b1, so);
    repeat (4) @(negedge clk);
    chk(rx_full, "R10 same-cycle read keeps new word full", rx_full, 1);
    chk(!overrun, "R10 same-cycle read no overrun", overrun, 0);
    chk(rd_data == 8'h9D, "R10 same-cycle read data", rd_data, 8'h9D);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule